// File: doc/BRIEF.md
# Audio Concealment and Zero-Cross Mute Stage

This block is the last per-sample stage of a 16-bit stereo playback path. Each incoming sample pair carries one error flag per channel, marking samples that the upstream correction could not repair. The stage hides flagged samples and applies an attenuation level selected by command bytes. It then steers the channels to the outputs. A raw mode hands the delayed samples straight through for data use.

Concealment works one sample behind the input, so it can see the sample that follows the one it is repairing. A lone flagged sample between good samples is replaced by the midpoint of its neighbours. Other flagged samples repeat the last emitted value. From the fourth flagged sample in a row onward the channel emits zero. Level changes wait until both channels sit near zero, so that no step is heard. Routing changes take effect on the next sample.

Top module: `pcm_conceal_stage`

## Requirements
- R1: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. Each output pair belongs to the pair accepted one step earlier. The first output after reset is a preloaded zero pair.
- R2: An unflagged sample passes unchanged at unity level with stereo routing.
- R3: A flagged sample whose previous sample and next sample are both unflagged is output as floor((previous output + next input) / 2). The sum is taken in signed two's complement arithmetic.
- R4: A flagged sample in position 1 to 3 of a flagged run, other than the isolated case in R3, outputs the channel's last emitted value.
- R5: A flagged sample in position 4 or later of a run outputs zero. Output returns to normal with the next unflagged sample.
- R6: Command 01h selects unity, 02h selects an arithmetic right shift by two (about -12 dB), and 03h selects silence (zero output). The level after reset is silence.
- R7: A requested level is applied first to a pair in which both channels' concealed samples have their top seven bits all equal. That pair already uses the new level. Until such a pair occurs, the old level stays in force.
- R8: Command 28h routes each channel to its own output, 29h routes left to both outputs, and 2Ah routes right to both outputs. The change applies to the next emitted pair. Routing after reset is stereo.
- R9: While `raw_mode` is high, the outputs carry the delayed input samples with no concealment, attenuation or routing.
- R10: Command bytes other than those in R6 and R8 change neither the level nor the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept one stereo sample pair |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| in_left_bad | input | 1 | Left sample is uncorrectable |
| in_right_bad | input | 1 | Right sample is uncorrectable |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command code |
| raw_mode | input | 1 | Bypass concealment, level and routing |
| out_valid | output | 1 | Output pair valid |
| out_left | output | 16 | Left output sample |
| out_right | output | 16 | Right output sample |

## Verification
The bench targets the boundary between interpolation and hold. A design that interpolated whenever the next sample was good would average the second sample of a two-sample run instead of repeating. A run of exactly four and five flags tests the zero limit: an off-by-one would leak a held value or silence a sample too early. A negative odd midpoint checks that the sum is rounded toward minus infinity. A level change held back by a pair outside the zero band checks the deferral, and a design that switched at once would unmute early. Raw mode with flagged samples and silence pending checks that neither concealment nor attenuation touches the data path.

// File: rtl/pcm_cs_pkg.sv
package pcm_cs_pkg;

    localparam int PCM_W = 16;

    typedef logic signed [PCM_W-1:0] pcm_t;

    typedef struct packed {
        pcm_t left;
        pcm_t right;
    } pcm_pair_t;

    typedef enum logic [1:0] {
        LVL_UNITY   = 2'd0,
        LVL_QUARTER = 2'd1,
        LVL_SILENT  = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        RT_STEREO = 2'd0,
        RT_LEFT   = 2'd1,
        RT_RIGHT  = 2'd2
    } route_e;

    localparam logic [7:0] OP_LVL_UNITY   = 8'h01;
    localparam logic [7:0] OP_LVL_QUARTER = 8'h02;
    localparam logic [7:0] OP_LVL_SILENT  = 8'h03;
    localparam logic [7:0] OP_RT_STEREO   = 8'h28;
    localparam logic [7:0] OP_RT_LEFT     = 8'h29;
    localparam logic [7:0] OP_RT_RIGHT    = 8'h2A;

    // floor of the signed average, computed one bit wider
    function automatic pcm_t midpoint(pcm_t a, pcm_t b);
        logic [PCM_W:0] s;
        s = {a[PCM_W-1], a} + {b[PCM_W-1], b};
        return pcm_t'(s[PCM_W:1]);
    endfunction

    function automatic pcm_t apply_level(pcm_t x, level_e lv);
        pcm_t r;
        case (lv)
            LVL_UNITY:   r = x;
            LVL_QUARTER: r = x >>> 2;
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/conceal_lane.sv
module conceal_lane
    import pcm_cs_pkg::*;
#(
    parameter int RUN_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  pcm_t nxt_val,
    input  logic nxt_bad,
    output pcm_t ctr_raw,
    output pcm_t ctr_fixed
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    pcm_t             ctr_q;
    pcm_t             hold_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;

    assign ctr_raw = ctr_q;

    always_comb begin
        if (run_q == '0)
            ctr_fixed = ctr_q;
        else if (run_q >= RUN_MAX)
            ctr_fixed = '0;
        else if (run_q == RUN_ONE && !nxt_bad)
            ctr_fixed = midpoint(hold_q, nxt_val);
        else
            ctr_fixed = hold_q;
    end

    always_comb begin
        if (!nxt_bad)
            run_d = '0;
        else if (run_q == RUN_MAX)
            run_d = run_q;
        else
            run_d = run_q + RUN_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q  <= '0;
            hold_q <= '0;
            run_q  <= '0;
        end else if (step) begin
            ctr_q  <= nxt_val;
            hold_q <= ctr_fixed;
            run_q  <= run_d;
        end
    end

    // R5: once the run reaches the limit, the remembered value is zero
    p_zero_after_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (step && run_q >= RUN_MAX) |=> (hold_q == '0));

    // R2: a clean incoming sample resets the run count
    p_run_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !nxt_bad) |=> (run_q == '0));

endmodule

// File: rtl/level_gate.sv
module level_gate
    import pcm_cs_pkg::*;
#(
    parameter int ZC_BITS = 7
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic   step,
    input  pcm_t   probe_l,
    input  pcm_t   probe_r,
    output level_e eff_level
);
    localparam logic [ZC_BITS-1:0] BAND_LO = '0;
    localparam logic [ZC_BITS-1:0] BAND_HI = '1;

    level_e active_q;
    level_e pending_q;
    logic   zc_l;
    logic   zc_r;
    logic   zc_both;

    assign zc_l    = (probe_l[PCM_W-1 -: ZC_BITS] == BAND_LO) ||
                     (probe_l[PCM_W-1 -: ZC_BITS] == BAND_HI);
    assign zc_r    = (probe_r[PCM_W-1 -: ZC_BITS] == BAND_LO) ||
                     (probe_r[PCM_W-1 -: ZC_BITS] == BAND_HI);
    assign zc_both = zc_l && zc_r;

    assign eff_level = zc_both ? pending_q : active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= LVL_SILENT;
            pending_q <= LVL_SILENT;
        end else begin
            if (step)
                active_q <= eff_level;
            if (cmd_valid) begin
                case (cmd_byte)
                    OP_LVL_UNITY:   pending_q <= LVL_UNITY;
                    OP_LVL_QUARTER: pending_q <= LVL_QUARTER;
                    OP_LVL_SILENT:  pending_q <= LVL_SILENT;
                    default:        pending_q <= pending_q;
                endcase
            end
        end
    end

    // R7: the applied level moves only on a sample inside the zero band
    p_switch_at_zc_r7: assert property (@(posedge clk) disable iff (rst)
        !(step && zc_both) |=> $stable(active_q));

    // R10: an unknown command byte leaves the requested level alone
    p_unknown_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte != OP_LVL_UNITY && cmd_byte != OP_LVL_QUARTER &&
         cmd_byte != OP_LVL_SILENT) |=> $stable(pending_q));

endmodule

// File: rtl/chan_router.sv
module chan_router
    import pcm_cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  logic [7:0] cmd_byte,
    input  pcm_pair_t src,
    output pcm_pair_t dst,
    output route_e    route_sel
);
    route_e route_q;

    assign route_sel = route_q;

    always_comb begin
        case (route_q)
            RT_LEFT:  dst = '{left: src.left,  right: src.left};
            RT_RIGHT: dst = '{left: src.right, right: src.right};
            default:  dst = src;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= RT_STEREO;
        end else if (cmd_valid) begin
            case (cmd_byte)
                OP_RT_STEREO: route_q <= RT_STEREO;
                OP_RT_LEFT:   route_q <= RT_LEFT;
                OP_RT_RIGHT:  route_q <= RT_RIGHT;
                default:      route_q <= route_q;
            endcase
        end
    end

    // R10: bytes outside the routing set keep the routing
    p_route_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || (cmd_byte != OP_RT_STEREO && cmd_byte != OP_RT_LEFT &&
                        cmd_byte != OP_RT_RIGHT)) |=> $stable(route_q));

endmodule

// File: rtl/pcm_conceal_stage.sv
module pcm_conceal_stage
    import pcm_cs_pkg::*;
#(
    parameter int RUN_LIMIT = 4,
    parameter int ZC_BITS   = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_left,
    input  logic [15:0] in_right,
    input  logic        in_left_bad,
    input  logic        in_right_bad,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_byte,
    input  logic        raw_mode,
    output logic        out_valid,
    output logic [15:0] out_left,
    output logic [15:0] out_right
);
    localparam int N_CH = 2;

    pcm_t      lane_in    [N_CH];
    logic      lane_bad   [N_CH];
    pcm_t      lane_raw   [N_CH];
    pcm_t      lane_fixed [N_CH];
    level_e    eff_level;
    route_e    route_sel;
    pcm_pair_t scaled;
    pcm_pair_t routed;
    pcm_pair_t result;

    assign lane_in[0]  = pcm_t'(in_left);
    assign lane_in[1]  = pcm_t'(in_right);
    assign lane_bad[0] = in_left_bad;
    assign lane_bad[1] = in_right_bad;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        conceal_lane #(.RUN_LIMIT(RUN_LIMIT)) lane_i (
            .clk       (clk),
            .rst       (rst),
            .step      (in_valid),
            .nxt_val   (lane_in[ch]),
            .nxt_bad   (lane_bad[ch]),
            .ctr_raw   (lane_raw[ch]),
            .ctr_fixed (lane_fixed[ch])
        );
    end

    level_gate #(.ZC_BITS(ZC_BITS)) gate_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .step      (in_valid),
        .probe_l   (lane_fixed[0]),
        .probe_r   (lane_fixed[1]),
        .eff_level (eff_level)
    );

    assign scaled.left  = apply_level(lane_fixed[0], eff_level);
    assign scaled.right = apply_level(lane_fixed[1], eff_level);

    chan_router router_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .src       (scaled),
        .dst       (routed),
        .route_sel (route_sel)
    );

    always_comb begin
        if (raw_mode)
            result = '{left: lane_raw[0], right: lane_raw[1]};
        else
            result = routed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= result.left;
                out_right <= result.right;
            end
        end
    end

    // R1: one output per accepted pair, one cycle later
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: silence gives zero on both outputs outside raw mode
    p_silent_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !raw_mode && eff_level == LVL_SILENT) |=>
        (out_left == '0 && out_right == '0));

    // R8: mono routing drives both outputs equal
    p_mono_equal_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !raw_mode && route_sel != RT_STEREO) |=>
        (out_left == out_right));

    // R9: raw mode emits the delayed samples untouched
    p_raw_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && raw_mode) |=>
        (out_left == $past(lane_raw[0]) && out_right == $past(lane_raw[1])));

endmodule

// File: tb/pcm_conceal_stage_tb.sv
module pcm_conceal_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_left;
    logic [15:0] in_right;
    logic        in_left_bad;
    logic        in_right_bad;
    logic        cmd_valid;
    logic [7:0]  cmd_byte;
    logic        raw_mode;
    logic        out_valid;
    logic [15:0] out_left;
    logic [15:0] out_right;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcm_conceal_stage dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_left      (in_left),
        .in_right     (in_right),
        .in_left_bad  (in_left_bad),
        .in_right_bad (in_right_bad),
        .cmd_valid    (cmd_valid),
        .cmd_byte     (cmd_byte),
        .raw_mode     (raw_mode),
        .out_valid    (out_valid),
        .out_left     (out_left),
        .out_right    (out_right)
    );

    // {in_l, in_r, bad_l, bad_r, exp_l, exp_r}; expected is the previous pair
    localparam int NV = 16;
    localparam logic [65:0] VEC [NV] = '{
        {16'h0100, 16'h0010, 1'b0, 1'b0, 16'h3000, 16'h3000},
        {16'h7777, 16'h0020, 1'b1, 1'b0, 16'h0100, 16'h0010},
        {16'h0300, 16'h0030, 1'b0, 1'b0, 16'h0200, 16'h0020},
        {16'h1111, 16'h0040, 1'b1, 1'b0, 16'h0300, 16'h0030},
        {16'h2222, 16'h0050, 1'b1, 1'b0, 16'h0300, 16'h0040},
        {16'h3333, 16'h0060, 1'b1, 1'b0, 16'h0300, 16'h0050},
        {16'h4444, 16'h0070, 1'b1, 1'b0, 16'h0300, 16'h0060},
        {16'h5555, 16'h0080, 1'b1, 1'b0, 16'h0000, 16'h0070},
        {16'h0500, 16'h0090, 1'b0, 1'b0, 16'h0000, 16'h0080},
        {16'h0600, 16'h7FFF, 1'b1, 1'b1, 16'h0500, 16'h0090},
        {16'h0700, 16'h00B0, 1'b1, 1'b0, 16'h0500, 16'h00A0},
        {16'h0800, 16'h00C0, 1'b0, 1'b0, 16'h0500, 16'h00B0},
        {16'hFF00, 16'h00D0, 1'b0, 1'b0, 16'h0800, 16'h00C0},
        {16'hAAAA, 16'h00E0, 1'b1, 1'b0, 16'hFF00, 16'h00D0},
        {16'hFD01, 16'h00F0, 1'b0, 1'b0, 16'hFE00, 16'h00E0},
        {16'h0002, 16'h0100, 1'b0, 1'b0, 16'hFD01, 16'h00F0}
    };

    localparam string VREQ [NV] = '{
        "R2", "R2", "R3", "R2", "R4", "R4", "R4", "R5",
        "R5", "R2", "R3", "R4", "R2", "R2", "R3", "R2"
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_cmd(logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(logic [15:0] l, logic [15:0] r, logic bl, logic br,
                        logic [15:0] el, logic [15:0] er, string req);
        @(negedge clk);
        in_valid     = 1'b1;
        in_left      = l;
        in_right     = r;
        in_left_bad  = bl;
        in_right_bad = br;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, "_valid"}, {15'd0, out_valid}, 16'd1);
        chk({req, "_left"},  out_left,  el);
        chk({req, "_right"}, out_right, er);
    endtask

    initial begin
        rst          = 1'b1;
        in_valid     = 1'b0;
        in_left      = '0;
        in_right     = '0;
        in_left_bad  = 1'b0;
        in_right_bad = 1'b0;
        cmd_valid    = 1'b0;
        cmd_byte     = '0;
        raw_mode     = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state (R1)
        chk("R1_reset_valid", {15'd0, out_valid}, 16'd0);
        chk("R1_reset_left", out_left, 16'h0000);
        chk("R1_reset_right", out_right, 16'h0000);

        // R1 preload, R6 silent after reset
        push(16'h4000, 16'h4000, 1'b0, 1'b0, 16'h0000, 16'h0000, "R1");
        push(16'h1000, 16'h2000, 1'b0, 1'b0, 16'h0000, 16'h0000, "R6");
        send_cmd(8'h01);
        // R7: pending unity waits, pair outside zero band
        push(16'h0010, 16'hFFF0, 1'b0, 1'b0, 16'h0000, 16'h0000, "R7");
        // R7: zero-band pair applies unity immediately
        push(16'h3000, 16'h3000, 1'b0, 1'b0, 16'h0010, 16'hFFF0, "R7");

        for (int i = 0; i < NV; i++) begin
            push(VEC[i][65:50], VEC[i][49:34], VEC[i][33], VEC[i][32],
                 VEC[i][31:16], VEC[i][15:0], VREQ[i]);
        end

        // R6: quarter level, applied at the zero-band pair
        send_cmd(8'h02);
        push(16'h0400, 16'h0800, 1'b0, 1'b0, 16'h0000, 16'h0040, "R6");
        push(16'hF000, 16'h0001, 1'b0, 1'b0, 16'h0100, 16'h0200, "R6");
        push(16'h0000, 16'h0000, 1'b0, 1'b0, 16'hFC00, 16'h0000, "R6");

        // R8 routing
        send_cmd(8'h01);
        send_cmd(8'h29);
        push(16'h1234, 16'h5678, 1'b0, 1'b0, 16'h0000, 16'h0000, "R8");
        push(16'h0AAA, 16'h0BBB, 1'b0, 1'b0, 16'h1234, 16'h1234, "R8");
        send_cmd(8'h2A);
        push(16'h0100, 16'h0200, 1'b0, 1'b0, 16'h0BBB, 16'h0BBB, "R8");
        send_cmd(8'h28);
        // R10: unknown bytes before a zero-band pair change nothing
        send_cmd(8'h04);
        send_cmd(8'h2B);
        push(16'h0111, 16'h0222, 1'b0, 1'b0, 16'h0100, 16'h0200, "R10");

        // R9 raw mode with silence pending and flagged samples
        send_cmd(8'h03);
        @(negedge clk);
        raw_mode = 1'b1;
        push(16'h7000, 16'h6000, 1'b1, 1'b1, 16'h0111, 16'h0222, "R9");
        push(16'h0001, 16'h0002, 1'b0, 1'b0, 16'h7000, 16'h6000, "R9");
        @(negedge clk);
        raw_mode = 1'b0;
        push(16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000, "R6");

        // R1: no output without input
        @(negedge clk);
        chk("R1_idle", {15'd0, out_valid}, 16'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule